// File: doc/BRIEF.md
# Dual-Bound Adaptive Background Subtractor

This block classifies each pixel of a frame stream against a background model that adapts over time. Every pixel owns two running-average trackers, an upper bound and a lower bound, held in a small state store indexed by pixel number. Together the two bounds form a grey zone. A sample inside the grey zone is ordinary background. A sample above the upper bound, or below the lower bound, by more than a fixed safety margin is flagged as hot on that side.

After the comparison, each bound moves toward the sample by an arithmetic-shift fraction of the distance. Each bound decides on its own how often it moves. A bound that is hot uses the fast frame divisor. A bound that is cold uses the slow divisor. When a bound switches between the two rates, its per-pixel frame counter starts again.

The bounds leave reset far apart on the wrong side of each other, so a learning run over a static scene is expected after start-up. An init strobe can instead load both bounds of a pixel directly with one sample.

Top module: `bsub_top`

## Requirements
- R1: Exactly one cycle after a cycle with `valid_i` high, `status_valid_o` is high and `status_idx_o` equals the pixel index that was presented.
- R2: `status_o[1]` (hot-max) is set when the sample exceeds the pixel's upper bound plus MARGIN. A sample equal to upper bound plus MARGIN, or lower, leaves it clear.
- R3: `status_o[0]` (hot-min) is set when the sample plus MARGIN is below the pixel's lower bound. A sample equal to lower bound minus MARGIN, or higher, leaves it clear.
- R4: Reset sets every upper bound to 0 and every lower bound to the full-scale value. A first sample strictly between MARGIN and full scale minus MARGIN therefore reports status 2'b11, and the block must still update both bounds from that state.
- R5: Each bound keeps a frame counter. A hot bound uses divisor `div_fast_i` and a cold bound uses `div_slow_i`, and the bound moves only on every N-th frame of its current mode. The counter restarts when the mode changes, so the first frame after a change counts as frame 1. A divisor of 0 acts as 1.
- R6: A bound that moves becomes bound + ((sample − bound) >>> `shift_i`), computed with signed arithmetic and held within 0 to full scale.
- R7: A valid sample with `init_i` high loads both bounds of that pixel with the sample, restarts both counters in the slow mode, and reports status 2'b00.
- R8: Only the presented pixel's state changes. Other pixels keep their bounds and counters.
- R9: Status is computed from the bounds as they stood before that frame's update. When `valid_i` was low in the previous cycle, `status_valid_o` and `status_o` are 0. During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe |
| init_i | input | 1 | Load both bounds of the pixel with the sample |
| pix_idx_i | input | IDX_W | Pixel index of the sample |
| sample_i | input | DATA_W | Pixel sample value |
| div_fast_i | input | CNT_W | Frame divisor for a hot bound |
| div_slow_i | input | CNT_W | Frame divisor for a cold bound |
| shift_i | input | SHIFT_W | Step shift applied to the bound-to-sample distance |
| status_valid_o | output | 1 | Status strobe, one cycle after `valid_i` |
| status_idx_o | output | IDX_W | Pixel index belonging to the status |
| status_o | output | 2 | Bit 1 hot-max, bit 0 hot-min |

## Verification
The assertions assume that `pix_idx_i` is below NUM_PIX whenever `valid_i` is high. They also assume that the divisors and the shift stay stable across any frame sequence whose timing is being judged. The bench drives indices from 0 to 3 only, keeps the fast divisor at 1 and the slow divisor at 4, and changes the shift only before starting a fresh pixel. Inputs change on the falling edge, so the index that an assertion recalls with `$past` is always the one that the rising edge captured.

// File: rtl/bsub_pkg.sv
package bsub_pkg;
  typedef enum logic {
    MODE_SLOW = 1'b0,
    MODE_FAST = 1'b1
  } rate_mode_e;

  localparam int unsigned ST_MAX_BIT = 1;
  localparam int unsigned ST_MIN_BIT = 0;
endpackage

// File: rtl/bsub_state_mem.sv
module bsub_state_mem #(
  parameter int unsigned NUM_PIX   = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned IDX_W     = 4,
  parameter logic [DATA_W-1:0] RST_BOUND = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] rd_bound_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              rd_fast_o,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wr_bound_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic              wr_fast_i
);
  logic [DATA_W-1:0] bound_q [NUM_PIX];
  logic [CNT_W-1:0]  cnt_q   [NUM_PIX];
  logic [NUM_PIX-1:0] fast_q;

  assign rd_bound_o = bound_q[idx_i];
  assign rd_cnt_o   = cnt_q[idx_i];
  assign rd_fast_o  = fast_q[idx_i];

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bound_q[p] <= RST_BOUND;
        cnt_q[p]   <= '0;
        fast_q[p]  <= 1'b0;
      end else if (we_i && (idx_i == IDX_W'(p))) begin
        bound_q[p] <= wr_bound_i;
        cnt_q[p]   <= wr_cnt_i;
        fast_q[p]  <= wr_fast_i;
      end
    end
  end
endmodule

// File: rtl/bsub_bound_trk.sv
module bsub_bound_trk
  import bsub_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned MARGIN  = 4,
  parameter bit          UPPER   = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [DATA_W-1:0]  bound_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  rate_mode_e         mode_i,
  input  logic [CNT_W-1:0]   div_fast_i,
  input  logic [CNT_W-1:0]   div_slow_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               hot_o,
  output logic [DATA_W-1:0]  bound_o,
  output logic [CNT_W-1:0]   cnt_o,
  output rate_mode_e         mode_o
);
  localparam int unsigned EW = DATA_W + 2;
  localparam logic signed [EW-1:0] MARG = EW'(MARGIN);

  logic signed [EW-1:0] s_w, b_w, diff_w, step_w, sum_w;
  logic [CNT_W-1:0] div_sel, div_eff, eff_cnt;
  logic [CNT_W:0]   eff_inc;
  logic             switched, fire;

  assign s_w = $signed({2'b00, sample_i});
  assign b_w = $signed({2'b00, bound_i});

  if (UPPER) begin : g_up
    assign hot_o = s_w > (b_w + MARG);
  end else begin : g_lo
    assign hot_o = (s_w + MARG) < b_w;
  end

  assign mode_o   = hot_o ? MODE_FAST : MODE_SLOW;
  assign switched = (mode_o != mode_i);

  // frame divider: restart on mode change, 0 behaves as 1
  assign div_sel = hot_o ? div_fast_i : div_slow_i;
  assign div_eff = (div_sel == '0) ? CNT_W'(1) : div_sel;
  assign eff_cnt = switched ? '0 : cnt_i;
  assign eff_inc = {1'b0, eff_cnt} + (CNT_W+1)'(1);
  assign fire    = eff_inc >= {1'b0, div_eff};
  assign cnt_o   = fire ? '0 : eff_inc[CNT_W-1:0];

  // first-order step with saturation
  assign diff_w = s_w - b_w;
  assign step_w = diff_w >>> shift_i;
  assign sum_w  = b_w + step_w;

  always_comb begin
    if (!fire)                bound_o = bound_i;
    else if (sum_w[EW-1])     bound_o = '0;
    else if (sum_w[EW-2])     bound_o = '1;
    else                      bound_o = sum_w[DATA_W-1:0];
  end

  a_r6_step_toward_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> ((bound_o >= ((sample_i < bound_i) ? sample_i : bound_i)) &&
              (bound_o <= ((sample_i > bound_i) ? sample_i : bound_i))));
endmodule

// File: rtl/bsub_top.sv
module bsub_top
  import bsub_pkg::*;
#(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned MARGIN  = 4,
  localparam int unsigned IDX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               init_i,
  input  logic [IDX_W-1:0]   pix_idx_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [CNT_W-1:0]   div_fast_i,
  input  logic [CNT_W-1:0]   div_slow_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               status_valid_o,
  output logic [IDX_W-1:0]   status_idx_o,
  output logic [1:0]         status_o
);
  logic [1:0] hot;

  // side 1 = upper bound (hot-max), side 0 = lower bound (hot-min)
  for (genvar g = 0; g < 2; g++) begin : g_side
    localparam bit UP = (g == 1);
    localparam logic [DATA_W-1:0] RST_B = UP ? {DATA_W{1'b0}} : {DATA_W{1'b1}};

    logic [DATA_W-1:0] rd_bound, nx_bound, wr_bound;
    logic [CNT_W-1:0]  rd_cnt, nx_cnt, wr_cnt;
    logic              rd_fast, wr_fast;
    rate_mode_e        nx_mode;

    bsub_state_mem #(
      .NUM_PIX(NUM_PIX), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .RST_BOUND(RST_B)
    ) u_mem (
      .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(pix_idx_i),
      .rd_bound_o(rd_bound), .rd_cnt_o(rd_cnt), .rd_fast_o(rd_fast),
      .we_i(valid_i), .wr_bound_i(wr_bound), .wr_cnt_i(wr_cnt), .wr_fast_i(wr_fast)
    );

    bsub_bound_trk #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .MARGIN(MARGIN), .UPPER(UP)
    ) u_trk (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sample_i(sample_i), .bound_i(rd_bound), .cnt_i(rd_cnt),
      .mode_i(rate_mode_e'(rd_fast)),
      .div_fast_i(div_fast_i), .div_slow_i(div_slow_i), .shift_i(shift_i),
      .hot_o(hot[g]), .bound_o(nx_bound), .cnt_o(nx_cnt), .mode_o(nx_mode)
    );

    assign wr_bound = init_i ? sample_i : nx_bound;
    assign wr_cnt   = init_i ? '0 : nx_cnt;
    assign wr_fast  = init_i ? 1'b0 : (nx_mode == MODE_FAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_valid_o <= 1'b0;
      status_idx_o   <= '0;
      status_o       <= 2'b00;
    end else begin
      status_valid_o <= valid_i;
      status_idx_o   <= valid_i ? pix_idx_i : '0;
      status_o[ST_MAX_BIT] <= valid_i && !init_i && hot[1];
      status_o[ST_MIN_BIT] <= valid_i && !init_i && hot[0];
    end
  end

  a_r1_status_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> status_valid_o);
  a_r1_index_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (status_idx_o == $past(pix_idx_i)));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!status_valid_o && (status_o == 2'b00)));
  a_r7_init_reports_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && init_i) |=> (status_o == 2'b00));
endmodule

// File: tb/tb_bsub_top.sv
`timescale 1ns/1ps
module tb_bsub_top;
  localparam int unsigned NV = 18;
  // {req[3:0], init, idx[3:0], sample[7:0], exp[1:0]}; fast div 1, slow div 4, shift 1, MARGIN 4
  localparam logic [18:0] VEC [NV] = '{
    {4'd4, 1'b0, 4'd0, 8'd100, 2'b11},  // R4 reset bounds straddle
    {4'd4, 1'b0, 4'd0, 8'd100, 2'b11},  // R4 U=50 L=177
    {4'd4, 1'b0, 4'd0, 8'd100, 2'b11},  // R4 U=75 L=138
    {4'd4, 1'b0, 4'd0, 8'd100, 2'b11},  // R4 U=87 L=119
    {4'd4, 1'b0, 4'd0, 8'd100, 2'b11},  // R4 U=93 L=109
    {4'd2, 1'b0, 4'd0, 8'd100, 2'b00},  // R2 U=96 L=104: both inside margin
    {4'd2, 1'b0, 4'd0, 8'd103, 2'b10},  // R2 hot-max
    {4'd3, 1'b0, 4'd0, 8'd90,  2'b01},  // R3 hot-min, U=99
    {4'd8, 1'b0, 4'd1, 8'd2,   2'b01},  // R8 pixel 1 still at reset bounds
    {4'd7, 1'b1, 4'd1, 8'd50,  2'b00},  // R7 init
    {4'd2, 1'b0, 4'd1, 8'd54,  2'b00},  // R2 exactly at U+MARGIN
    {4'd2, 1'b0, 4'd1, 8'd55,  2'b10},  // R2 one above
    {4'd3, 1'b0, 4'd1, 8'd46,  2'b00},  // R3 exactly at L-MARGIN
    {4'd5, 1'b0, 4'd1, 8'd46,  2'b00},  // R5 L slow fires on 4th frame -> 48
    {4'd3, 1'b0, 4'd1, 8'd30,  2'b01},  // R3 L=48 hot
    {4'd5, 1'b0, 4'd1, 8'd40,  2'b00},  // R5 U slow fires after restart -> 46
    {4'd5, 1'b0, 4'd1, 8'd51,  2'b10},  // R5 proves U moved to 46
    {4'd8, 1'b0, 4'd0, 8'd90,  2'b01}   // R8 pixel 0 kept U=99 L=97
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0, init_i = 1'b0;
  logic [3:0] pix_idx_i = '0;
  logic [7:0] sample_i = '0;
  logic [5:0] div_fast_i = 6'd1, div_slow_i = 6'd4;
  logic [2:0] shift_i = 3'd1;
  logic       status_valid_o;
  logic [3:0] status_idx_o;
  logic [1:0] status_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bsub_top dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .init_i(init_i),
    .pix_idx_i(pix_idx_i), .sample_i(sample_i),
    .div_fast_i(div_fast_i), .div_slow_i(div_slow_i), .shift_i(shift_i),
    .status_valid_o(status_valid_o), .status_idx_o(status_idx_o), .status_o(status_o)
  );

  task automatic check(input bit ok, input int req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic ini, input logic [3:0] idx, input logic [7:0] smp,
                       input logic [1:0] exp, input int req);
    @(negedge clk);
    init_i = ini; pix_idx_i = idx; sample_i = smp; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; init_i = 1'b0;
    check(status_valid_o && (status_o == exp), req, {status_valid_o, status_o}, {1'b1, exp});
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 outputs quiet in reset
    check(!status_valid_o && status_o == 2'b00, 9, {status_valid_o, status_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!status_valid_o && status_o == 2'b00, 9, {status_valid_o, status_o}, 0);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][14], VEC[i][13:10], VEC[i][9:2], VEC[i][1:0], int'(VEC[i][18:15]));

    // R1 latency and index echo on pixel 3 (reset bounds, so R4 code 11)
    @(negedge clk);
    check(!status_valid_o, 9, status_valid_o, 0);  // R9 idle cycle
    pix_idx_i = 4'd3; sample_i = 8'd128; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; pix_idx_i = 4'd0;
    check(status_valid_o == 1'b1, 1, status_valid_o, 1);  // R1
    check(status_idx_o == 4'd3, 1, status_idx_o, 3);      // R1
    check(status_o == 2'b11, 4, status_o, 3);             // R4
    @(negedge clk);
    check(!status_valid_o && status_o == 2'b00, 9, {status_valid_o, status_o}, 0);  // R9

    // R6 shift 3 on pixel 2
    shift_i = 3'd3;
    apply(1'b1, 4'd2, 8'd0,   2'b00, 7);  // R7
    apply(1'b0, 4'd2, 8'd200, 2'b10, 6);  // R6 U -> 25
    apply(1'b0, 4'd2, 8'd200, 2'b10, 6);  // R6 U -> 46
    apply(1'b0, 4'd2, 8'd49,  2'b00, 6);  // R6 49 <= 50
    apply(1'b0, 4'd2, 8'd51,  2'b10, 6);  // R6 51 > 50

    report();
  end
endmodule